// File: doc/BRIEF.md
# Table-Driven Time-Slot Scheduler

This block decides, one clock at a time, which of several cores owns a shared resource. The decision comes from a small table. Each table entry holds the number of a core. A pointer moves through the table by one entry per clock. It returns to entry zero when it reaches a programmable wrap length. The entry under the pointer is read synchronously, and one clock later it appears as the grant. The grant is given both as a core number and as a one-hot vector.

Software controls the schedule entirely. It can give a core several slots in a row, which keeps a read-modify-write sequence free of interruption. It can hand out unequal shares, or shorten the cycle by lowering the wrap length. After reset the table and the wrap length give every one of the 16 cores one slot in a fixed order of 16.

Top module: `slot_sched`

## Requirements
- R1: While reset is high, grant_valid is 0, grant_id is 0 and grant_vec is all zeros. Reset loads table entry i with the value i mod 16, sets the wrap length to 16 and sets the pointer to entry 0.
- R2: On the first rising edge after reset is released, grant_valid goes to 1 and grant_id becomes 0. With the table and wrap length left at their reset values, later grants follow 0, 1, ..., 15, 0, ..., one per clock.
- R3: Each grant is the table entry the pointer selected on the previous edge. grant_vec is one-hot, and its bit number grant_id is the one set whenever grant_valid is 1.
- R4: The wrap length register is 6 bits wide. For a written value M from 1 to 32, the pointer visits entries 0 to M-1 in turn and then returns to 0.
- R5: A written wrap length of 0, or any value from 33 to 63, behaves as 32.
- R6: On the edge that captures a wrap length write, the pointer returns to 0. The grant produced at that edge still comes from the old pointer position, and the grant after it comes from entry 0.
- R7: A table write (5-bit address, 4-bit core number) changes the entry when the write is captured. A write to the entry being read on that same edge leaves that grant at the old value, and the new value is granted on the pointer's next visit.
- R8: Consecutive table entries that hold the same core produce grants to that core on consecutive clocks.
- R9: With a wrap length of 1, every grant comes from entry 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one time slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 5 | Table entry to write |
| tbl_data | input | 4 | Core number to store |
| mod_we | input | 1 | Wrap length write strobe |
| mod_data | input | 6 | New wrap length |
| grant_valid | output | 1 | A grant is being presented |
| grant_id | output | 4 | Core owning the current slot |
| grant_vec | output | 16 | One-hot form of grant_id |

## Verification
The case that is hardest to reach from the ports is a table write whose address equals the entry being read on the same edge. The pointer is not visible at the ports. The bench therefore tracks the pointer arithmetically in its own model and times the write to land exactly on the current read position. It then keeps running until the pointer returns to that entry, so the new value can be observed. Every 6-bit wrap length value, including zero and the out-of-range values, is swept. Before each sweep step the table is reloaded with a pattern that changes from step to step.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;

    localparam int NUM_CORES = 16;
    localparam int TBL_DEPTH = 32;
    localparam int CORE_W    = $clog2(NUM_CORES);
    localparam int IDX_W     = $clog2(TBL_DEPTH);
    localparam int MOD_W     = IDX_W + 1;
    localparam int RESET_MOD = NUM_CORES;

    typedef logic [CORE_W-1:0] core_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [MOD_W-1:0]  mod_t;

    typedef struct packed {
        logic  valid;
        core_t core;
    } grant_t;

    // Usable wrap length: zero or beyond the table means the full table.
    function automatic mod_t span_of(input mod_t m);
        if (m == '0 || m > mod_t'(TBL_DEPTH))
            return mod_t'(TBL_DEPTH);
        return m;
    endfunction

    function automatic idx_t advance(input idx_t p, input mod_t m);
        mod_t inc;
        inc = mod_t'(p) + mod_t'(1);
        if (inc >= span_of(m))
            return '0;
        return inc[IDX_W-1:0];
    endfunction

endpackage

// File: rtl/slot_table.sv
module slot_table
    import slot_sched_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  idx_t   wr_addr,
    input  core_t  wr_data,
    input  idx_t   rd_addr,
    output grant_t rd_out
);

    core_t mem [TBL_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TBL_DEPTH; i++)
                mem[i] <= core_t'(i % NUM_CORES);
            rd_out <= '0;
        end else begin
            rd_out.valid <= 1'b1;
            rd_out.core  <= mem[rd_addr];
            if (wr_en)
                mem[wr_addr] <= wr_data;
        end
    end

endmodule

// File: rtl/slot_pointer.sv
module slot_pointer
    import slot_sched_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mod_we,
    input  mod_t mod_data,
    output idx_t ptr,
    output mod_t mod_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr   <= '0;
            mod_q <= mod_t'(RESET_MOD);
        end else if (mod_we) begin
            ptr   <= '0;
            mod_q <= mod_data;
        end else begin
            ptr   <= advance(ptr, mod_q);
        end
    end

endmodule

// File: rtl/grant_decode.sv
module grant_decode
    import slot_sched_pkg::*;
(
    input  grant_t               g,
    output logic [NUM_CORES-1:0] vec
);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_bit
        assign vec[c] = g.valid && (g.core == core_t'(c));
    end

endmodule

// File: rtl/slot_sched.sv
module slot_sched
    import slot_sched_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tbl_we,
    input  logic [IDX_W-1:0]     tbl_addr,
    input  logic [CORE_W-1:0]    tbl_data,
    input  logic                 mod_we,
    input  logic [MOD_W-1:0]     mod_data,
    output logic                 grant_valid,
    output logic [CORE_W-1:0]    grant_id,
    output logic [NUM_CORES-1:0] grant_vec
);

    idx_t   ptr_q;
    mod_t   mod_q;
    grant_t grant;

    slot_pointer u_ptr (
        .clk      (clk),
        .rst      (rst),
        .mod_we   (mod_we),
        .mod_data (mod_data),
        .ptr      (ptr_q),
        .mod_q    (mod_q)
    );

    slot_table u_tbl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tbl_we),
        .wr_addr (tbl_addr),
        .wr_data (tbl_data),
        .rd_addr (ptr_q),
        .rd_out  (grant)
    );

    grant_decode u_dec (
        .g   (grant),
        .vec (grant_vec)
    );

    assign grant_valid = grant.valid;
    assign grant_id    = grant.core;

endmodule

// File: rtl/slot_sched_chk.sv
module slot_sched_chk
    import slot_sched_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 mod_we,
    input logic                 grant_valid,
    input logic [CORE_W-1:0]    grant_id,
    input logic [NUM_CORES-1:0] grant_vec,
    input idx_t                 ptr,
    input mod_t                 mod_q
);

    p_valid_after_reset_r2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> grant_valid);

    p_onehot_grant_r3: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> ($countones(grant_vec) == 1 && grant_vec[grant_id]));

    p_ptr_in_span_r4: assert property (@(posedge clk) disable iff (rst)
        mod_t'(ptr) < span_of(mod_q));

    p_last_entry_wraps_r4: assert property (@(posedge clk) disable iff (rst)
        (ptr == idx_t'(TBL_DEPTH - 1)) |=> (ptr == '0));

    p_full_span_steps_r5: assert property (@(posedge clk) disable iff (rst)
        ((mod_q == '0 || mod_q > mod_t'(TBL_DEPTH)) && !mod_we &&
         ptr != idx_t'(TBL_DEPTH - 1)) |=> (ptr == $past(ptr) + idx_t'(1)));

    p_mod_write_restarts_r6: assert property (@(posedge clk) disable iff (rst)
        mod_we |=> (ptr == '0));

    p_span_one_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (mod_q == mod_t'(1) && !mod_we) |=> (ptr == '0));

endmodule

bind slot_sched slot_sched_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .mod_we      (mod_we),
    .grant_valid (grant_valid),
    .grant_id    (grant_id),
    .grant_vec   (grant_vec),
    .ptr         (ptr_q),
    .mod_q       (mod_q)
);

// File: tb/slot_sched_test.sv
module slot_sched_test;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        tbl_we;
    logic [4:0]  tbl_addr;
    logic [3:0]  tbl_data;
    logic        mod_we;
    logic [5:0]  mod_data;
    logic        grant_valid;
    logic [3:0]  grant_id;
    logic [15:0] grant_vec;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    int mtbl [32];
    int mptr;
    int mmod;

    always #(PERIOD/2) clk = ~clk;

    slot_sched uut (
        .clk         (clk),
        .rst         (rst),
        .tbl_we      (tbl_we),
        .tbl_addr    (tbl_addr),
        .tbl_data    (tbl_data),
        .mod_we      (mod_we),
        .mod_data    (mod_data),
        .grant_valid (grant_valid),
        .grant_id    (grant_id),
        .grant_vec   (grant_vec)
    );

    function automatic int span(input int m);
        return (m == 0 || m > 32) ? 32 : m;
    endfunction

    // Inputs are already driven; model one edge, then compare at the negedge.
    task automatic tick(input string tag);
        logic        ev;
        int          eid;
        logic [15:0] evec;
        if (rst) begin
            ev = 1'b0; eid = 0;
            for (int i = 0; i < 32; i++) mtbl[i] = i % 16;
            mptr = 0; mmod = 16;
        end else begin
            ev = 1'b1; eid = mtbl[mptr];
            if (tbl_we) mtbl[int'(tbl_addr)] = int'(tbl_data);
            if (mod_we) begin
                mmod = int'(mod_data); mptr = 0;
            end else begin
                mptr = (mptr + 1 >= span(mmod)) ? 0 : mptr + 1;
            end
        end
        evec = ev ? (16'h1 << eid) : 16'h0;
        @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (grant_valid !== ev || grant_id !== 4'(eid) || grant_vec !== evec) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b id=%0d vec=%h, want valid=%0b id=%0d vec=%h",
                     tag, grant_valid, grant_id, grant_vec, ev, eid, evec);
        end
        tbl_we = 1'b0;
        mod_we = 1'b0;
    endtask

    task automatic put(input int a, input int d, input string tag);
        tbl_we = 1'b1; tbl_addr = 5'(a); tbl_data = 4'(d);
        tick(tag);
    endtask

    task automatic set_mod(input int m, input string tag);
        mod_we = 1'b1; mod_data = 6'(m);
        tick(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no finish, want finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tbl_we = 1'b0; tbl_addr = '0; tbl_data = '0;
        mod_we = 1'b0; mod_data = '0;
        mptr = 0; mmod = 16;
        @(negedge clk);
        for (int i = 0; i < 3; i++) tick("R1 reset outputs");
        rst = 1'b0;

        // R2 / R3: default 1-in-16 rotation
        for (int i = 0; i < 40; i++) tick("R2 default rotation");

        // R7: write lands on the entry being read this edge
        begin
            int hit;
            hit = mptr;
            put(hit, mtbl[hit] ^ 15, "R7 same-edge write keeps old grant");
            for (int i = 0; i < 20; i++) tick("R7 new value on next pass");
        end
        // R7: write just ahead of the pointer
        put((mptr + 1) % 16, 3, "R7 write ahead");
        for (int i = 0; i < 4; i++) tick("R7 write ahead seen");

        // R4 / R5 / R6 / R9: sweep every wrap length value
        for (int m = 0; m < 64; m++) begin
            string tg;
            tg = (m == 0 || m > 32) ? "R5 illegal length as 32" :
                 (m == 1)           ? "R9 length one" : "R4 wrap length";
            for (int a = 0; a < 32; a++) put(a, (a * 7 + m) % 16, "R7 table load");
            set_mod(m, "R6 length write restarts pointer");
            tick("R6 entry zero after length write");
            for (int i = 0; i < 2 * span(m) + 1; i++) tick(tg);
        end

        // R8: back-to-back ownership
        put(0, 5, "R8 load"); put(1, 5, "R8 load");
        put(2, 5, "R8 load"); put(3, 9, "R8 load");
        set_mod(4, "R6 length write");
        for (int i = 0; i < 12; i++) tick("R8 repeated core consecutive");

        // R1: reset mid-run restores defaults
        rst = 1'b1;
        for (int i = 0; i < 2; i++) tick("R1 reset outputs");
        rst = 1'b0;
        for (int i = 0; i < 34; i++) tick("R1 defaults restored");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule